// File: doc/BRIEF.md
# Delay-Slot Branch Sequencer with Likely-Branch Squash

This block owns the program counter of a small in-order core whose control transfers have one architectural delay slot. On every retire strobe it looks at the opcode of the retiring instruction, compares the two source operands, and works out where the next instruction comes from. It handles equal and not-equal conditional branches, the absolute jump, and the jump that saves a return address. It also handles the equal branch-likely form, which cancels its delay slot when the branch is not taken.

A taken branch or a jump arms a one-shot redirect. The delay-slot instruction that follows retires normally, and the armed target is then applied. An ordinary branch that is not taken lets its delay slot run and carries on in sequence. A branch-likely that is not taken moves the PC straight past the slot. It also raises a one-cycle squash flag, so that the fetch side drops the delay-slot instruction it has already fetched. The register file, fetch and hazard logic sit outside the block. The block only produces the PC, the squash flag and the link-write request.

Top module: `dslot_seq`

## Requirements
- R1: After reset, pcOut equals the BOOT_VEC parameter (default 32'hBFC0_0000), slotSquash is low and no redirect is armed.
- R2: A retire of any opcode that is not a control transfer, outside a delay slot, advances pcOut by 4 at the next clock edge.
- R3: A retire of the equal branch (opcode 6'h04) with rsVal==rtVal, or of the not-equal branch (opcode 6'h05) with rsVal!=rtVal, advances pcOut by 4. The retire after it (the delay slot) then loads pcOut with slotPc + (sign-extended brOffset << 2), where slotPc is the branch PC plus 4.
- R4: An equal or not-equal branch whose condition fails advances pcOut by 4 and arms nothing. Its delay slot then retires, and the sequence continues at the branch PC plus 8.
- R5: The equal branch-likely (opcode 6'h14) with rsVal==rtVal behaves like a taken equal branch: its delay slot executes, slotSquash stays low, and the target is then applied.
- R6: The equal branch-likely with rsVal!=rtVal sets pcOut to the branch PC plus 8 at the next edge, arms no redirect, and drives slotSquash high for exactly that one cycle.
- R7: The jump (opcode 6'h02) and the jump-and-link (opcode 6'h03) advance pcOut by 4. After the delay slot retires, pcOut becomes {slotPc[31:28], jmpIndex, 2'b00}.
- R8: While the jump-and-link retires outside a delay slot, linkWe is high, linkIdx is 31 and linkData is pcOut + 8. linkWe is low otherwise.
- R9: ctrlOp is high exactly when the opcode is one of 6'h02, 6'h03, 6'h04, 6'h05, 6'h14, so the branch-likely is never grouped with the unrecognised or sequential opcodes.
- R10: With retireValid low, pcOut and the armed redirect do not change.
- R11: A control-transfer opcode that retires in a delay slot is not decoded as a branch. It neither arms a new redirect nor requests a link write, and pcOut goes to the already armed target.
- R12: An armed redirect is consumed by exactly one retire. The retire after the delay slot advances pcOut by 4 from the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| retireValid | input | 1 | One instruction retires this cycle |
| opcode | input | 6 | Primary opcode field of the retiring instruction |
| rsVal | input | 32 | First source operand value |
| rtVal | input | 32 | Second source operand value |
| brOffset | input | 16 | Branch word offset, signed |
| jmpIndex | input | 26 | Jump word index |
| pcOut | output | 32 | PC of the instruction that retires next |
| slotSquash | output | 1 | Discard the fetched delay slot (one cycle) |
| ctrlOp | output | 1 | Opcode is a supported control transfer |
| linkWe | output | 1 | Write return address to the link register |
| linkIdx | output | 5 | Link register index |
| linkData | output | 32 | Return address |

## Verification
The hardest case to reach is a control-transfer opcode that arrives while a redirect is armed. It only happens when a taken branch is followed at once by a branch or jump-and-link in its delay slot. The bench retires a taken equal branch and then a jump-and-link in the slot. It checks that no link write is requested, that the PC lands on the first target, and that the retire after that steps by 4. The one-cycle squash pulse is pinned down by an idle cycle after the not-taken branch-likely. This shows that the flag drops even without a further retire.

// File: rtl/dslot_pkg.sv
package dslot_pkg;

  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_J    = 6'h02;
  localparam logic [OPC_W-1:0] OPC_JAL  = 6'h03;
  localparam logic [OPC_W-1:0] OPC_BEQ  = 6'h04;
  localparam logic [OPC_W-1:0] OPC_BNE  = 6'h05;
  localparam logic [OPC_W-1:0] OPC_BEQL = 6'h14;

  localparam logic [4:0] LINK_REG = 5'd31;

  // strobes from control to datapath, already qualified by retire
  typedef struct packed {
    logic seqStep;    // advance by one word
    logic skipSlot;   // advance by two words (annulled slot)
    logic armBranch;  // arm relative branch target
    logic armJump;    // arm region jump target
    logic takePend;   // apply armed target, disarm
    logic setSquash;  // flag annulled slot
    logic link;       // request return-address write
  } seqStrobe_t;

endpackage

// File: rtl/dslot_ctrl.sv
module dslot_ctrl
  import dslot_pkg::*;
(
  input  logic             retireValid,
  input  logic             inSlot,
  input  logic [OPC_W-1:0] opcode,
  input  logic [31:0]      rsVal,
  input  logic [31:0]      rtVal,
  output logic             ctrlOp,
  output seqStrobe_t       strobe
);

  logic isJ, isJal, isBeq, isBne, isBeql;
  logic opsEqual;
  logic condTaken;
  logic decodeOn;

  always_comb begin
    isJ    = (opcode == OPC_J);
    isJal  = (opcode == OPC_JAL);
    isBeq  = (opcode == OPC_BEQ);
    isBne  = (opcode == OPC_BNE);
    isBeql = (opcode == OPC_BEQL);
    ctrlOp = isJ | isJal | isBeq | isBne | isBeql;
  end

  always_comb begin
    opsEqual  = (rsVal == rtVal);
    condTaken = ((isBeq | isBeql) & opsEqual) | (isBne & ~opsEqual);
  end

  // branches are only decoded outside a delay slot
  assign decodeOn = retireValid & ~inSlot;

  always_comb begin
    strobe = '0;
    if (retireValid && inSlot) begin
      strobe.takePend = 1'b1;
    end else if (decodeOn) begin
      if (isBeql && !opsEqual) begin
        strobe.skipSlot  = 1'b1;
        strobe.setSquash = 1'b1;
      end else begin
        strobe.seqStep   = 1'b1;
        strobe.armBranch = condTaken;
        strobe.armJump   = isJ | isJal;
        strobe.link      = isJal;
      end
    end
  end

endmodule

// File: rtl/dslot_path.sv
module dslot_path
  import dslot_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          OFF_W    = 16,
  parameter int          IDX_W    = 26,
  parameter logic [31:0] BOOT_VEC = 32'hBFC0_0000
)(
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [OFF_W-1:0] brOffset,
  input  logic [IDX_W-1:0] jmpIndex,
  output logic [XLEN-1:0]  pcOut,
  output logic             inSlot,
  output logic             slotSquash,
  output logic             linkWe,
  output logic [4:0]       linkIdx,
  output logic [XLEN-1:0]  linkData
);

  localparam int            EXT_W  = XLEN - OFF_W - 2;
  localparam int            HI_W   = XLEN - IDX_W - 2;
  localparam logic [XLEN-1:0] WORD   = XLEN'(4);
  localparam logic [XLEN-1:0] DWORD  = XLEN'(8);

  logic [XLEN-1:0] pcQ, pcD;
  logic [XLEN-1:0] pendQ, pendD;
  logic            pendValidQ, pendValidD;
  logic            squashQ;

  logic [XLEN-1:0] slotPc;
  logic [XLEN-1:0] relOffset;
  logic [XLEN-1:0] brTarget;
  logic [XLEN-1:0] jTarget;

  always_comb begin
    slotPc    = pcQ + WORD;
    relOffset = {{EXT_W{brOffset[OFF_W-1]}}, brOffset, 2'b00};
    brTarget  = slotPc + relOffset;
    jTarget   = {slotPc[XLEN-1 -: HI_W], jmpIndex, 2'b00};
  end

  always_comb begin
    pcD        = pcQ;
    pendD      = pendQ;
    pendValidD = pendValidQ;
    if (strobe.takePend) begin
      pcD        = pendQ;
      pendValidD = 1'b0;
    end else if (strobe.skipSlot) begin
      pcD = pcQ + DWORD;
    end else if (strobe.seqStep) begin
      pcD = slotPc;
    end
    if (strobe.armBranch) begin
      pendD      = brTarget;
      pendValidD = 1'b1;
    end else if (strobe.armJump) begin
      pendD      = jTarget;
      pendValidD = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ        <= XLEN'(BOOT_VEC);
      pendQ      <= '0;
      pendValidQ <= 1'b0;
      squashQ    <= 1'b0;
    end else begin
      pcQ        <= pcD;
      pendQ      <= pendD;
      pendValidQ <= pendValidD;
      squashQ    <= strobe.setSquash;
    end
  end

  assign pcOut      = pcQ;
  assign inSlot     = pendValidQ;
  assign slotSquash = squashQ;
  assign linkWe     = strobe.link;
  assign linkIdx    = LINK_REG;
  assign linkData   = pcQ + DWORD;

endmodule

// File: rtl/dslot_seq.sv
module dslot_seq
  import dslot_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter logic [31:0] BOOT_VEC = 32'hBFC0_0000
)(
  input  logic            clk,
  input  logic            rstN,
  input  logic            retireValid,
  input  logic [5:0]      opcode,
  input  logic [31:0]     rsVal,
  input  logic [31:0]     rtVal,
  input  logic [15:0]     brOffset,
  input  logic [25:0]     jmpIndex,
  output logic [XLEN-1:0] pcOut,
  output logic            slotSquash,
  output logic            ctrlOp,
  output logic            linkWe,
  output logic [4:0]      linkIdx,
  output logic [XLEN-1:0] linkData
);

  seqStrobe_t strobe;
  logic       inSlot;

  dslot_ctrl ctrl_i (
    .retireValid (retireValid),
    .inSlot      (inSlot),
    .opcode      (opcode),
    .rsVal       (rsVal),
    .rtVal       (rtVal),
    .ctrlOp      (ctrlOp),
    .strobe      (strobe)
  );

  dslot_path #(
    .XLEN     (XLEN),
    .OFF_W    (16),
    .IDX_W    (26),
    .BOOT_VEC (BOOT_VEC)
  ) path_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .brOffset   (brOffset),
    .jmpIndex   (jmpIndex),
    .pcOut      (pcOut),
    .inSlot     (inSlot),
    .slotSquash (slotSquash),
    .linkWe     (linkWe),
    .linkIdx    (linkIdx),
    .linkData   (linkData)
  );

endmodule

// File: rtl/dslot_seq_chk.sv
module dslot_seq_chk
  import dslot_pkg::*;
#(
  parameter int XLEN = 32
)(
  input logic            clk,
  input logic            rstN,
  input logic            retireValid,
  input logic [5:0]      opcode,
  input logic [31:0]     rsVal,
  input logic [31:0]     rtVal,
  input logic [XLEN-1:0] pcOut,
  input logic            slotSquash,
  input logic            linkWe,
  input logic            inSlot
);

  logic freeRetire;
  assign freeRetire = retireValid && !inSlot;

  // R6: not-taken branch-likely skips the slot and flags the squash
  p_likely_skip_r6: assert property (@(posedge clk) disable iff (!rstN)
    (freeRetire && opcode == OPC_BEQL && rsVal != rtVal)
      |=> (slotSquash && !inSlot && pcOut == $past(pcOut) + XLEN'(8)));

  // R6: squash never coexists with an armed redirect
  p_squash_unarmed_r6: assert property (@(posedge clk) disable iff (!rstN)
    slotSquash |-> !inSlot);

  // R4: failed ordinary branch steps one word and arms nothing
  p_plain_fall_r4: assert property (@(posedge clk) disable iff (!rstN)
    (freeRetire && ((opcode == OPC_BEQ && rsVal != rtVal) ||
                    (opcode == OPC_BNE && rsVal == rtVal)))
      |=> (!inSlot && !slotSquash && pcOut == $past(pcOut) + XLEN'(4)));

  // R3: taken branch arms a redirect and enters the slot
  p_taken_arm_r3: assert property (@(posedge clk) disable iff (!rstN)
    (freeRetire && (((opcode == OPC_BEQ || opcode == OPC_BEQL) && rsVal == rtVal) ||
                    (opcode == OPC_BNE && rsVal != rtVal)))
      |=> (inSlot && pcOut == $past(pcOut) + XLEN'(4)));

  // R12: armed redirect lasts one retire
  p_slot_once_r12: assert property (@(posedge clk) disable iff (!rstN)
    (inSlot && retireValid) |=> !inSlot);

  // R10: idle cycles hold state
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !retireValid |=> ($stable(pcOut) && $stable(inSlot)));

  // R8: a link request always opens a delay slot
  p_link_slot_r8: assert property (@(posedge clk) disable iff (!rstN)
    linkWe |=> inSlot);

  // R11: no link request from inside a delay slot
  p_slot_nolink_r11: assert property (@(posedge clk) disable iff (!rstN)
    inSlot |-> !linkWe);

endmodule

bind dslot_seq dslot_seq_chk #(.XLEN(XLEN)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .retireValid (retireValid),
  .opcode      (opcode),
  .rsVal       (rsVal),
  .rtVal       (rtVal),
  .pcOut       (pcOut),
  .slotSquash  (slotSquash),
  .linkWe      (linkWe),
  .inSlot      (inSlot)
);

// File: tb/dslot_seq_tb.sv
module dslot_seq_tb_top;

  localparam logic [31:0] BOOT = 32'hBFC0_0000;
  localparam logic [5:0] O_J = 6'h02, O_JAL = 6'h03, O_BEQ = 6'h04,
                         O_BNE = 6'h05, O_BEQL = 6'h14, O_ADD = 6'h09;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        retireValid = 1'b0;
  logic [5:0]  opcode = '0;
  logic [31:0] rsVal = '0, rtVal = '0;
  logic [15:0] brOffset = '0;
  logic [25:0] jmpIndex = '0;
  logic [31:0] pcOut, linkData;
  logic        slotSquash, ctrlOp, linkWe;
  logic [4:0]  linkIdx;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dslot_seq #(.XLEN(32), .BOOT_VEC(BOOT)) dut_i (
    .clk(clk), .rstN(rstN), .retireValid(retireValid), .opcode(opcode),
    .rsVal(rsVal), .rtVal(rtVal), .brOffset(brOffset), .jmpIndex(jmpIndex),
    .pcOut(pcOut), .slotSquash(slotSquash), .ctrlOp(ctrlOp),
    .linkWe(linkWe), .linkIdx(linkIdx), .linkData(linkData)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, clock once, return at next negedge
  task automatic retire(input logic [5:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [15:0] off,
                        input logic [25:0] idx);
    opcode = op; rsVal = a; rtVal = b; brOffset = off; jmpIndex = idx;
    retireValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    retireValid = 1'b0;
  endtask

  task automatic idle();
    retireValid = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] relTgt(input logic [31:0] bpc, input logic [15:0] off);
    return bpc + 32'd4 + {{14{off[15]}}, off, 2'b00};
  endfunction

  task automatic t_reset();
    check(pcOut == BOOT, "R1 pc", pcOut, BOOT);
    check(slotSquash == 1'b0, "R1 squash", 32'(slotSquash), 0);
  endtask

  task automatic t_seq();
    logic [31:0] p = pcOut;
    retire(O_ADD, 1, 2, 16'h0005, 26'h1);
    check(pcOut == p + 4, "R2 step", pcOut, p + 4);
  endtask

  task automatic t_beq_taken();
    logic [31:0] p = pcOut;
    logic [31:0] t = relTgt(p, 16'h0010);
    retire(O_BEQ, 32'h55, 32'h55, 16'h0010, 26'h0);
    check(pcOut == p + 4, "R3 beq slot pc", pcOut, p + 4);
    retire(O_ADD, 0, 0, 16'h0, 26'h0);
    check(pcOut == t, "R3 beq target", pcOut, t);
    retire(O_ADD, 0, 0, 16'h0, 26'h0);
    check(pcOut == t + 4, "R12 after target", pcOut, t + 4);
  endtask

  task automatic t_bne_back();
    logic [31:0] p = pcOut;
    logic [31:0] t = relTgt(p, 16'hFFF0);
    retire(O_BNE, 32'h1, 32'h2, 16'hFFF0, 26'h0);
    check(pcOut == p + 4, "R3 bne slot pc", pcOut, p + 4);
    retire(O_ADD, 0, 0, 16'h0, 26'h0);
    check(pcOut == t, "R3 bne back target", pcOut, t);
  endtask

  task automatic t_plain_fall();
    logic [31:0] p = pcOut;
    retire(O_BEQ, 32'h1, 32'h2, 16'h0040, 26'h0);
    check(pcOut == p + 4, "R4 beq nt slot", pcOut, p + 4);
    check(slotSquash == 1'b0, "R4 no squash", 32'(slotSquash), 0);
    retire(O_ADD, 0, 0, 16'h0, 26'h0);
    check(pcOut == p + 8, "R4 continue", pcOut, p + 8);
    p = pcOut;
    retire(O_BNE, 32'h7, 32'h7, 16'h0040, 26'h0);
    retire(O_ADD, 0, 0, 16'h0, 26'h0);
    check(pcOut == p + 8, "R4 bne nt continue", pcOut, p + 8);
  endtask

  task automatic t_likely_taken();
    logic [31:0] p = pcOut;
    logic [31:0] t = relTgt(p, 16'h0020);
    retire(O_BEQL, 32'hA, 32'hA, 16'h0020, 26'h0);
    check(pcOut == p + 4, "R5 slot runs", pcOut, p + 4);
    check(slotSquash == 1'b0, "R5 no squash", 32'(slotSquash), 0);
    retire(O_ADD, 0, 0, 16'h0, 26'h0);
    check(pcOut == t, "R5 target", pcOut, t);
  endtask

  task automatic t_likely_squash();
    logic [31:0] p = pcOut;
    retire(O_BEQL, 32'hA, 32'hB, 16'h0020, 26'h0);
    check(pcOut == p + 8, "R6 skip pc", pcOut, p + 8);
    check(slotSquash == 1'b1, "R6 squash high", 32'(slotSquash), 1);
    idle();
    check(slotSquash == 1'b0, "R6 squash one cycle", 32'(slotSquash), 0);
    retire(O_ADD, 0, 0, 16'h0, 26'h0);
    check(pcOut == p + 12, "R6 nothing armed", pcOut, p + 12);
  endtask

  task automatic t_jal();
    logic [31:0] p = pcOut;
    logic [31:0] t = {p[31:28] + 4'(((p + 4) >> 28) - (p >> 28)), 26'h0ABCDE, 2'b00};
    t = {((p + 32'd4) >> 28) & 32'hF, 28'h0} | {4'h0, 26'h0ABCDE, 2'b00};
    opcode = O_JAL; jmpIndex = 26'h0ABCDE; retireValid = 1'b1;
    #1;
    check(linkWe == 1'b1, "R8 link we", 32'(linkWe), 1);
    check(linkIdx == 5'd31, "R8 link idx", 32'(linkIdx), 31);
    check(linkData == p + 8, "R8 link data", linkData, p + 8);
    retire(O_JAL, 0, 0, 16'h0, 26'h0ABCDE);
    check(linkWe == 1'b0, "R8 link low after", 32'(linkWe), 0);
    check(pcOut == p + 4, "R7 jal slot", pcOut, p + 4);
    retire(O_ADD, 0, 0, 16'h0, 26'h0);
    check(pcOut == t, "R7 jal target", pcOut, t);
    p = pcOut;
    t = {((p + 32'd4) >> 28) & 32'hF, 28'h0} | {4'h0, 26'h0000040, 2'b00};
    retire(O_J, 0, 0, 16'h0, 26'h0000040);
    retire(O_ADD, 0, 0, 16'h0, 26'h0);
    check(pcOut == t, "R7 j target", pcOut, t);
  endtask

  task automatic t_idle_hold();
    logic [31:0] p = pcOut;
    opcode = O_BEQ; rsVal = 0; rtVal = 0; brOffset = 16'h0100;
    idle();
    idle();
    check(pcOut == p, "R10 hold", pcOut, p);
    retire(O_ADD, 0, 0, 16'h0, 26'h0);
    check(pcOut == p + 4, "R10 nothing armed", pcOut, p + 4);
  endtask

  task automatic t_ctrl_in_slot();
    logic [31:0] p = pcOut;
    logic [31:0] t = relTgt(p, 16'h0008);
    retire(O_BEQ, 3, 3, 16'h0008, 26'h0);
    opcode = O_JAL; jmpIndex = 26'h0000123; retireValid = 1'b1;
    #1;
    check(linkWe == 1'b0, "R11 no link in slot", 32'(linkWe), 0);
    retire(O_JAL, 0, 0, 16'h0, 26'h0000123);
    check(pcOut == t, "R11 armed target wins", pcOut, t);
    retire(O_ADD, 0, 0, 16'h0, 26'h0);
    check(pcOut == t + 4, "R11 no new redirect", pcOut, t + 4);
  endtask

  task automatic t_classes();
    logic [5:0] ops [8] = '{O_J, O_JAL, O_BEQ, O_BNE, O_BEQL, O_ADD, 6'h00, 6'h15};
    bit exp [8] = '{1, 1, 1, 1, 1, 0, 0, 0};
    for (int i = 0; i < 8; i++) begin
      opcode = ops[i];
      #1;
      check(ctrlOp == exp[i], "R9 class", 32'(ctrlOp), 32'(exp[i]));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_seq();
    t_beq_taken();
    t_bne_back();
    t_plain_fall();
    t_likely_taken();
    t_likely_squash();
    t_jal();
    t_idle_hold();
    t_ctrl_in_slot();
    t_classes();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule